// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the per-processor controller of a direct-mapped, write-back cache. It keeps the cache coherent with peer caches that share one bus. Each line holds one of four states. A processor access that the current line state allows completes in the cycle it is presented. Any other access holds the processor stalled. The controller then requests the bus and issues a command: a read, a read with intent to write, an upgrade that only invalidates, or a writeback. It completes the access once the line state permits it.

Alongside its own traffic, the controller watches every transaction that peer caches place on the bus. It checks each snooped address against its tag array. Snooped ownership requests drop the matching local copy. When a peer reads a line that is dirty here, this cache supplies the data and tells memory to stay silent. A write to a line known to be the only cached copy never touches the bus.

Top module: `snoopCacheCtrl`

## Requirements
- R1: After reset every line is Invalid. With no request pending, `cpuStall`, `busReq` and `busCmdValid` are low, and the first access to any address misses.
- R2: A read whose line is valid with a matching tag completes in the cycle it is presented (`cpuStall` low) and returns the cached word on `cpuRData`, with no bus command.
- R3: A read miss issues command 0 (read). On `busRespValid` it fills the line with `busRespData`. If `busSharedIn` is 1 in that cycle, the line is Shared, so a later write issues an upgrade. If it is 0, the line is Exclusive, so a later write is silent.
- R4: A write that hits an Exclusive or Modified line completes locally with no bus command and makes the line Modified (dirty).
- R5: A write miss issues command 1 (read-exclusive), fills from the response, and then completes the write.
- R6: A write hit on a Shared line raises `busReq` and stalls until `busGrant`. It then issues command 2 (upgrade) with no data response and completes.
- R7: A snooped command 1 or 2 whose address matches a valid line invalidates that line. A later local read of it issues a read and returns the fresh bus data.
- R8: A snooped read (command 0) that matches a Modified line drives `snpSharedOut`=1, `snpAbortOut`=1 and the line's word on `snpData`. The line becomes Shared, so a later local write needs an upgrade.
- R9: A snooped read that matches an Exclusive or Shared line drives `snpSharedOut`=1 and `snpAbortOut`=0.
- R10: A miss whose index holds a Modified line with another tag first issues command 3 (writeback) with the old address and data on `busAddr`/`busWData`. It then issues the fill command for the new address.
- R11: If a peer's ownership request invalidates the line while a Shared-line write waits for the grant, the granted command is read-exclusive instead of upgrade. The write then lands on the freshly fetched line.
- R12: When a snoop and a local access target the same index in one cycle, the snoop is applied first and the local access stalls for that cycle. The access completes on the next cycle using the updated state.
- R13: A snoop whose tag does not match the local line has no effect: both snoop responses stay low and the local line still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until not stalled |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWData | input | DATA_W | Write data |
| cpuRData | output | DATA_W | Read data, valid when the access completes |
| cpuStall | output | 1 | High while a requested access cannot complete |
| busReq | output | 1 | Bus arbitration request |
| busGrant | input | 1 | Bus grant from the arbiter |
| busCmdValid | output | 1 | This cache issues a command this cycle |
| busCmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| busAddr | output | ADDR_W | Address of the issued command |
| busWData | output | DATA_W | Writeback data |
| busRespValid | input | 1 | Fill data for this cache's read is present |
| busRespData | input | DATA_W | Fill data |
| busSharedIn | input | 1 | Wired shared line, sampled with the fill |
| snpValid | input | 1 | A peer transaction is on the bus |
| snpCmd | input | 2 | Peer command, same encoding as `busCmd` |
| snpAddr | input | ADDR_W | Peer address |
| snpSharedOut | output | 1 | This cache holds the snooped line |
| snpAbortOut | output | 1 | This cache supplies dirty data; memory must not answer |
| snpData | output | DATA_W | Data supplied for a dirty snoop hit |

## Verification
A table of processor accesses runs the line states through each transition. The patterns are reads with the shared wire high and low, then writes to Exclusive, Shared and empty lines, then an eviction of a dirty line. The command list recorded for each access separates a silent write from an upgrade, a read-exclusive and a writeback-plus-fill. Directed snoop sequences then tell apart dirty and clean hits, ownership kills, and a tag that only aliases the index. The last two cases are a same-cycle snoop and local access to one index, and a lost upgrade race in which the granted command has to change to read-exclusive.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_READX = 2'd1,
    BC_UPGR  = 2'd2,
    BC_WBACK = 2'd3
  } busCmd_t;

  // strobes from the control FSM to the line arrays
  typedef struct packed {
    logic       cpuWrite;   // commit processor write, line -> Modified
    logic       fillEn;     // install response data and tag
    lineState_t fillState;  // state given to the filled line
    logic       upgEn;      // upgrade done, line -> Exclusive
    logic       evictEn;    // writeback done, line -> Invalid
  } ctrlStrobe_t;

endpackage

// File: rtl/snoopDatapath.sv
module snoopDatapath
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              snpValid,
  input  busCmd_t           snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output lineState_t        localState,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] victimData,
  output logic [DATA_W-1:0] rdData,
  output logic              snpShared,
  output logic              snpAbort,
  output logic [DATA_W-1:0] snpData,
  output logic              snpConflict
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        lineSt   [LINES];
  logic [TAG_W-1:0]  lineTag  [LINES];
  logic [DATA_W-1:0] lineData [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             tagMatch, snpHit, snpKills, snpReads;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  // local lookup
  assign tagMatch    = (lineTag[cpuIdx] == cpuTag);
  assign localState  = (lineSt[cpuIdx] != LS_INV && tagMatch) ? lineSt[cpuIdx] : LS_INV;
  assign victimDirty = (lineSt[cpuIdx] == LS_MOD) && !tagMatch;
  assign victimAddr  = {lineTag[cpuIdx], cpuIdx};
  assign victimData  = lineData[cpuIdx];
  assign rdData      = lineData[cpuIdx];

  // snoop lookup on the same tag array
  assign snpHit      = snpValid && (lineSt[snpIdx] != LS_INV) && (lineTag[snpIdx] == snpTag);
  assign snpKills    = (snpCmd == BC_READX) || (snpCmd == BC_UPGR);
  assign snpReads    = (snpCmd == BC_READ) || (snpCmd == BC_READX);
  assign snpShared   = snpHit && snpReads;
  assign snpAbort    = snpHit && snpReads && (lineSt[snpIdx] == LS_MOD);
  assign snpData     = lineData[snpIdx];
  assign snpConflict = snpValid && (snpIdx == cpuIdx);

  // one state register, tag and data word per line
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic selCpu, selSnp;
    assign selCpu = (cpuIdx == IDX_W'(g));
    assign selSnp = snpHit && (snpIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineSt[g] <= LS_INV;
      end else begin
        if (selCpu && strobe.cpuWrite) lineSt[g] <= LS_MOD;
        if (selCpu && strobe.fillEn)   lineSt[g] <= strobe.fillState;
        if (selCpu && strobe.upgEn)    lineSt[g] <= LS_EXC;
        if (selCpu && strobe.evictEn)  lineSt[g] <= LS_INV;
        // snoop has the last word on the state
        if (selSnp) begin
          if (snpKills)                lineSt[g] <= LS_INV;
          else if (snpCmd == BC_READ)  lineSt[g] <= LS_SHR;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (selCpu && strobe.cpuWrite) lineData[g] <= cpuWData;
      if (selCpu && strobe.fillEn) begin
        lineTag[g]  <= cpuTag;
        lineData[g] <= busRespData;
      end
    end
  end

  AST_ABORT_NEEDS_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    snpAbort |-> snpShared); // R8

  AST_SNOOP_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (snpHit && snpKills) |=> (lineSt[$past(snpIdx)] == LS_INV)); // R7

endmodule

// File: rtl/snoopControl.sv
module snoopControl
  import snoop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  lineState_t  localState,
  input  logic        victimDirty,
  input  logic        snpConflict,
  input  logic        busGrant,
  input  logic        busRespValid,
  input  logic        busSharedIn,
  output logic        cpuStall,
  output ctrlStrobe_t strobe,
  output logic        busReq,
  output logic        busCmdValid,
  output busCmd_t     busCmd
);

  typedef enum logic [1:0] {CT_IDLE, CT_ARB, CT_WAIT} ctState_t;

  ctState_t ctSt, ctNext;
  logic     pendExcl;
  logic     hitOk, cpuDone;
  busCmd_t  needCmd;

  assign hitOk   = (localState != LS_INV) &&
                   (!cpuWe || localState == LS_EXC || localState == LS_MOD);
  // snoop on the same index wins this cycle; retry on the next one
  assign cpuDone  = cpuReq && (ctSt == CT_IDLE) && hitOk && !snpConflict;
  assign cpuStall = cpuReq && !cpuDone;

  // command re-derived every cycle while waiting, so a lost race is seen
  always_comb begin
    if (victimDirty)                          needCmd = BC_WBACK;
    else if (cpuWe && localState == LS_SHR)   needCmd = BC_UPGR;
    else if (cpuWe)                           needCmd = BC_READX;
    else                                      needCmd = BC_READ;
  end

  assign busReq      = (ctSt == CT_ARB);
  assign busCmdValid = (ctSt == CT_ARB) && busGrant;
  assign busCmd      = needCmd;

  always_comb begin
    strobe           = '0;
    strobe.fillState = LS_INV;
    ctNext           = ctSt;
    strobe.cpuWrite  = cpuDone && cpuWe;
    case (ctSt)
      CT_IDLE: if (cpuReq && !hitOk && !snpConflict) ctNext = CT_ARB;
      CT_ARB: if (busGrant) begin
        case (needCmd)
          BC_WBACK: begin strobe.evictEn = 1'b1; ctNext = CT_IDLE; end
          BC_UPGR:  begin strobe.upgEn   = 1'b1; ctNext = CT_IDLE; end
          default:  ctNext = CT_WAIT;
        endcase
      end
      CT_WAIT: if (busRespValid) begin
        strobe.fillEn    = 1'b1;
        strobe.fillState = (pendExcl || !busSharedIn) ? LS_EXC : LS_SHR;
        ctNext           = CT_IDLE;
      end
      default: ctNext = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctSt     <= CT_IDLE;
      pendExcl <= 1'b0;
    end else begin
      ctSt <= ctNext;
      if (busCmdValid) pendExcl <= (needCmd == BC_READX);
    end
  end

  AST_UPG_ONLY_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && busCmd == BC_UPGR) |-> (localState == LS_SHR)); // R11

  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdValid && busCmd != BC_WBACK) |-> !victimDirty); // R10

  AST_FILL_MAKES_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (ctSt == CT_WAIT && busRespValid) |=> (localState != LS_INV)); // R3

  AST_SILENT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !cpuStall) |-> !busCmdValid); // R4

endmodule

// File: rtl/snoopCacheCtrl.sv
module snoopCacheCtrl
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  output logic [DATA_W-1:0] cpuRData,
  output logic              cpuStall,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busCmdValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  input  logic              busRespValid,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              busSharedIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpSharedOut,
  output logic              snpAbortOut,
  output logic [DATA_W-1:0] snpData
);

  ctrlStrobe_t       strobe;
  lineState_t        localState;
  logic              victimDirty, snpConflict;
  logic [ADDR_W-1:0] victimAddr;
  busCmd_t           ctlCmd;

  snoopDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuAddr     (cpuAddr),
    .cpuWData    (cpuWData),
    .strobe      (strobe),
    .busRespData (busRespData),
    .snpValid    (snpValid),
    .snpCmd      (busCmd_t'(snpCmd)),
    .snpAddr     (snpAddr),
    .localState  (localState),
    .victimDirty (victimDirty),
    .victimAddr  (victimAddr),
    .victimData  (busWData),
    .rdData      (cpuRData),
    .snpShared   (snpSharedOut),
    .snpAbort    (snpAbortOut),
    .snpData     (snpData),
    .snpConflict (snpConflict)
  );

  snoopControl i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .localState   (localState),
    .victimDirty  (victimDirty),
    .snpConflict  (snpConflict),
    .busGrant     (busGrant),
    .busRespValid (busRespValid),
    .busSharedIn  (busSharedIn),
    .cpuStall     (cpuStall),
    .strobe       (strobe),
    .busReq       (busReq),
    .busCmdValid  (busCmdValid),
    .busCmd       (ctlCmd)
  );

  assign busCmd  = ctlCmd;
  assign busAddr = (ctlCmd == BC_WBACK) ? victimAddr : cpuAddr;

endmodule

// File: tb/test_snoopCacheCtrl.sv
module test_snoopCacheCtrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic [31:0] cpuRData;
  logic        cpuStall, busReq, busGrant, busCmdValid;
  logic [1:0]  busCmd;
  logic [15:0] busAddr;
  logic [31:0] busWData;
  logic        busRespValid = 1'b0, busSharedIn = 1'b0;
  logic [31:0] busRespData = '0;
  logic        snpValid = 1'b0;
  logic [1:0]  snpCmd = '0;
  logic [15:0] snpAddr = '0;
  logic        snpSharedOut, snpAbortOut;
  logic [31:0] snpData;
  logic        allowGrant = 1'b1;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;
  assign busGrant = busReq && allowGrant;

  snoopCacheCtrl i_snoopCacheCtrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(cpuRData), .cpuStall(cpuStall), .busReq(busReq),
    .busGrant(busGrant), .busCmdValid(busCmdValid), .busCmd(busCmd), .busAddr(busAddr),
    .busWData(busWData), .busRespValid(busRespValid), .busRespData(busRespData),
    .busSharedIn(busSharedIn), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSharedOut(snpSharedOut), .snpAbortOut(snpAbortOut), .snpData(snpData)
  );

  localparam logic [1:0] RD = 2'd0, RX = 2'd1, UP = 2'd2, WB = 2'd3;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        sh;
    logic [31:0] resp;
    logic [1:0]  nCmd;
    logic [1:0]  c0;
    logic [1:0]  c1;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0010, 32'h0,        1'b0, 32'h0000A001, 2'd1, RD, RD, 32'h0000A001}, // R3 exclusive fill
    '{1'b1, 16'h0010, 32'h0000B001, 1'b0, 32'h0,        2'd0, RD, RD, 32'h0},        // R4 silent write
    '{1'b0, 16'h0010, 32'h0,        1'b0, 32'h0,        2'd0, RD, RD, 32'h0000B001}, // R2 hit
    '{1'b0, 16'h0021, 32'h0,        1'b1, 32'h0000C002, 2'd1, RD, RD, 32'h0000C002}, // R3 shared fill
    '{1'b1, 16'h0021, 32'h0000D002, 1'b0, 32'h0,        2'd1, UP, RD, 32'h0},        // R6 upgrade
    '{1'b0, 16'h0021, 32'h0,        1'b0, 32'h0,        2'd0, RD, RD, 32'h0000D002}, // R2
    '{1'b1, 16'h0032, 32'h0000E003, 1'b0, 32'h00000099, 2'd1, RX, RD, 32'h0},        // R5
    '{1'b0, 16'h0032, 32'h0,        1'b0, 32'h0,        2'd0, RD, RD, 32'h0000E003}, // R5
    '{1'b0, 16'h0110, 32'h0,        1'b0, 32'h0000F004, 2'd2, WB, RD, 32'h0000F004}, // R10
    '{1'b1, 16'h0110, 32'h0000A005, 1'b0, 32'h0,        2'd0, RD, RD, 32'h0}         // R4
  };

  logic [1:0]  logCmd  [4];
  logic [15:0] logAddr [4];
  logic [31:0] logData [4];
  int          nLog;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // runs one processor access to completion, playing the bus side
  task automatic doOp(input logic we, input logic [15:0] a, input logic [31:0] wd,
                      input logic sh, input logic [31:0] resp, output logic [31:0] rd);
    bit respPend = 0;
    bit done = 0;
    nLog = 0;
    rd = '0;
    @(negedge clk);
    allowGrant = 1'b1;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWData = wd;
    for (int c = 0; c < 40; c++) begin
      #1;
      if (busCmdValid) begin
        if (nLog < 4) begin
          logCmd[nLog] = busCmd; logAddr[nLog] = busAddr; logData[nLog] = busWData;
        end
        nLog++;
        if (busCmd == RD || busCmd == RX) respPend = 1;
      end
      if (!cpuStall) begin rd = cpuRData; done = 1; end
      @(negedge clk);
      busRespValid = respPend; busSharedIn = sh; busRespData = resp;
      respPend = 0;
      if (done) break;
    end
    if (!done) check(1'b0, "timeout", 32'd0, 32'd1);
    cpuReq = 1'b0; busRespValid = 1'b0;
  endtask

  task automatic snoopOp(input logic [1:0] cmd, input logic [15:0] a,
                         output logic sh, output logic ab, output logic [31:0] d);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = a;
    #1;
    sh = snpSharedOut; ab = snpAbortOut; d = snpData;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, sd;
    logic sh, ab;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!cpuStall && !busReq && !busCmdValid, "R1 idle outputs", {busCmdValid, busReq, cpuStall}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].we, VECS[i].addr, VECS[i].wd, VECS[i].sh, VECS[i].resp, rd);
      check(nLog == int'(VECS[i].nCmd), $sformatf("R3-R10 vec%0d cmd count", i), nLog, VECS[i].nCmd);
      if (VECS[i].nCmd > 0)
        check(logCmd[0] == VECS[i].c0, $sformatf("vec%0d first cmd", i), logCmd[0], VECS[i].c0);
      if (VECS[i].nCmd > 1)
        check(logCmd[1] == VECS[i].c1, $sformatf("vec%0d second cmd", i), logCmd[1], VECS[i].c1);
      if (!VECS[i].we)
        check(rd == VECS[i].exp, $sformatf("R2 vec%0d read data", i), rd, VECS[i].exp);
    end

    // R8 dirty snoop hit
    snoopOp(RD, 16'h0110, sh, ab, sd);
    check(sh && ab, "R8 shared+abort", {ab, sh}, 32'd3);
    check(sd == 32'h0000A005, "R8 supplied data", sd, 32'h0000A005);
    doOp(1'b1, 16'h0110, 32'h0000A006, 1'b0, 32'h0, rd);
    check(nLog == 1 && logCmd[0] == UP, "R8 write after supply upgrades", logCmd[0], UP);

    // R9 clean snoop hit
    doOp(1'b0, 16'h0043, 32'h0, 1'b0, 32'h00000043, rd);
    snoopOp(RD, 16'h0043, sh, ab, sd);
    check(sh && !ab, "R9 clean hit shared only", {ab, sh}, 32'd1);
    doOp(1'b1, 16'h0043, 32'h0000C043, 1'b0, 32'h0, rd);
    check(nLog == 1 && logCmd[0] == UP, "R9 line now shared", logCmd[0], UP);

    // R13 alias tag
    snoopOp(RX, 16'h0153, sh, ab, sd);
    check(!sh && !ab, "R13 no response", {ab, sh}, 32'd0);
    doOp(1'b0, 16'h0043, 32'h0, 1'b0, 32'h0, rd);
    check(nLog == 0 && rd == 32'h0000C043, "R13 line untouched", rd, 32'h0000C043);

    // R7 ownership snoop kills
    snoopOp(RX, 16'h0043, sh, ab, sd);
    doOp(1'b0, 16'h0043, 32'h0, 1'b0, 32'h0000D043, rd);
    check(nLog == 1 && logCmd[0] == RD, "R7 miss after kill", nLog, 32'd1);
    check(rd == 32'h0000D043, "R7 fresh data", rd, 32'h0000D043);

    // R12 snoop and local access on one index together
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 16'h0043;
    snpValid = 1'b1; snpCmd = RD; snpAddr = 16'h0043;
    #1;
    check(cpuStall == 1'b1, "R12 stalled behind snoop", cpuStall, 32'd1);
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    check(!cpuStall && cpuRData == 32'h0000D043, "R12 completes next cycle", cpuRData, 32'h0000D043);
    @(negedge clk);
    cpuReq = 1'b0;

    // R10 writeback of dirty victim
    doOp(1'b0, 16'h0121, 32'h0, 1'b0, 32'h00001121, rd);
    check(nLog == 2 && logCmd[0] == WB && logCmd[1] == RD, "R10 wb then read", {logCmd[0], logCmd[1]}, {WB, RD});
    check(logAddr[0] == 16'h0021 && logData[0] == 32'h0000D002, "R10 victim addr/data", logData[0], 32'h0000D002);
    check(logAddr[1] == 16'h0121 && rd == 32'h00001121, "R10 fill", rd, 32'h00001121);

    // R11 lost upgrade race
    doOp(1'b0, 16'h0055, 32'h0, 1'b1, 32'h00005500, rd);
    @(negedge clk);
    allowGrant = 1'b0;
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 16'h0055; cpuWData = 32'h0000005A;
    @(negedge clk); #1;
    check(busReq && cpuStall, "R6 waits for grant", {busReq, cpuStall}, 32'd3);
    snpValid = 1'b1; snpCmd = UP; snpAddr = 16'h0055;
    @(negedge clk);
    snpValid = 1'b0;
    doOp(1'b1, 16'h0055, 32'h0000005A, 1'b0, 32'h00007777, rd);
    check(nLog == 1 && logCmd[0] == RX, "R11 reissued as read-exclusive", logCmd[0], RX);
    doOp(1'b0, 16'h0055, 32'h0, 1'b0, 32'h0, rd);
    check(nLog == 0 && rd == 32'h0000005A, "R11 own write on fresh copy", rd, 32'h0000005A);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule